// File: doc/BRIEF.md
# Stored-State Sequencer Word Loader

This block feeds a power-sequencing engine with its active state definition. The definitions are not kept in any on-chip table. Each one is a 64-bit word in a 512-byte nonvolatile region that holds 64 slots of 8 bytes. The loader reads the required word one byte at a time over a byte-wide storage read port, waits out a fixed load time, and then presents the word to the sequencing datapath.

After reset the loader fetches slot `FIRST_IDX` on its own. From then on the datapath pulses `cond_met` together with the index of the following state, and the loader fetches that slot. `busy` stays high for the whole byte fetch and the timed delay. The active word and index only change at the moment `busy` falls. The last slot is reserved. A request for it raises a one-cycle error pulse and leaves the engine in its current state. Because every transition reads storage again, any change written into storage takes effect on the next fetch of that slot.

Back-pressure on the storage port works as follows. Once the loader raises `rd_req_valid`, it keeps `rd_addr` steady until a cycle in which `rd_req_ready` is high. That cycle completes the handshake. The loader never has more than one read outstanding and does not raise a new request until the byte has come back. The response side has no ready signal: the loader takes `rd_data` in any cycle where `rd_data_valid` is high while a read is pending.

Top module: `seq_state_loader`

## Requirements
- R1: While reset is held and until the first load completes, `busy` is 1, `state_word` is 0 and `idx_err` is 0. After reset is released the loader fetches slot `FIRST_IDX` (default 0) without any strobe.
- R2: For an accepted fetch of slot n, the loader reads byte addresses n*8 through n*8+7 in ascending order. The byte read from n*8+k becomes bits [8k+7:8k] of `state_word`, so byte 0 is least significant. `cur_idx` becomes n.
- R3: `state_word` and `cur_idx` keep their previous values for as long as `busy` is high. They change only in the cycle where `busy` falls.
- R4: A `cond_met` strobe that is accepted makes `busy` go high in the next cycle. If storage grants and answers each byte within one cycle, `busy` stays high for exactly LOAD_CYCLES+1 cycles, where LOAD_CYCLES = CLK_MHZ*LOAD_NS/1000 (2000 by default, 10 us at 200 MHz).
- R5: A `cond_met` strobe that arrives while `busy` is high is ignored. The fetch in progress completes with its own slot, and no further fetch follows.
- R6: A `cond_met` strobe with `next_idx` equal to `RESERVED_IDX` (default 63) makes `idx_err` high for exactly the next cycle. It starts no fetch, so `busy` stays 0, and it leaves `state_word` and `cur_idx` unchanged.
- R7: If a slot's bytes are changed in storage, the next fetch of that slot delivers the new contents.
- R8: `rd_req_valid` stays high with a stable `rd_addr` until `rd_req_ready` is seen. Only one read is outstanding at a time, and the reserved slot is never addressed.
- R9: If storage is slow enough that the bytes arrive after the delay has expired, the load finishes only once all 8 bytes have arrived. In that case `busy` is high for more than LOAD_CYCLES+1 cycles and the word is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | output | 1 | Storage read request valid |
| rd_req_ready | input | 1 | Storage accepts the request |
| rd_addr | output | 9 | Byte address of the read |
| rd_data_valid | input | 1 | Read data strobe |
| rd_data | input | 8 | Read data byte |
| cond_met | input | 1 | Active state's exit condition satisfied |
| next_idx | input | 6 | Slot of the following state |
| state_word | output | 64 | Active 64-bit state definition |
| cur_idx | output | 6 | Slot of the active state |
| busy | output | 1 | Fetch or load delay in progress |
| idx_err | output | 1 | One-cycle pulse: reserved slot requested |

## Verification
Storage is tried in three ways: granting and answering at once, granting on an irregular pattern, and granting only once every few hundred cycles. The first pins down the exact busy length. The second checks that the address is held under back-pressure and that bytes are ordered correctly. The third shows that a load waits for the last byte rather than for the timer alone. Slot sequences that go forwards, go backwards and revisit a slot expose any mistake in the index-to-address mapping. Directed cases cover a strobe during busy, a reserved index, and a storage edit followed by a reload, each observed through `state_word`, `cur_idx`, `busy` and `idx_err`.

// File: rtl/sll_pkg.sv
package sll_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_DONE = 2'd3
  } fetch_st_t;
endpackage

// File: rtl/sll_byte_fetch.sv
module sll_byte_fetch
  import sll_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int WORD_BYTES = 8,
  localparam int CNT_W     = $clog2(WORD_BYTES),
  localparam int ADDR_W    = IDX_W + CNT_W,
  localparam int WORD_W    = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  slot,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  fetch_st_t        st_q;
  logic [IDX_W-1:0] slot_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take      = (st_q == FS_WAIT) && rsp_valid;
  assign req_valid = (st_q == FS_REQ);
  assign addr      = {slot_q, cnt_q};
  assign done_o    = (st_q == FS_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      st_q   <= FS_REQ;
      slot_q <= slot;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        FS_REQ:  if (req_ready) st_q <= FS_WAIT;
        FS_WAIT: if (rsp_valid) begin
          if (cnt_q == CNT_W'(WORD_BYTES - 1)) begin
            st_q <= FS_DONE;
          end else begin
            st_q  <= FS_REQ;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= st_q;
      endcase
    end
  end

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_o[b*8 +: 8] <= '0;
      end else if (take && cnt_q == CNT_W'(b)) begin
        word_o[b*8 +: 8] <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/sll_load_timer.sv
module sll_load_timer #(
  parameter int CYCLES = 2000,
  localparam int CW    = $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(CYCLES - 1));
  assign expired_o = run_q && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && !at_end) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sll_index_guard.sv
module sll_index_guard #(
  parameter int IDX_W        = 6,
  parameter int RESERVED_IDX = 63
) (
  input  logic             cond_met,
  input  logic             idle,
  input  logic [IDX_W-1:0] next_idx,
  output logic             accept,
  output logic             reject
);
  logic hit_res;
  assign hit_res = (next_idx == IDX_W'(RESERVED_IDX));
  assign accept  = cond_met && idle && !hit_res;
  assign reject  = cond_met && idle && hit_res;
endmodule

// File: rtl/seq_state_loader.sv
module seq_state_loader #(
  parameter int IDX_W        = 6,
  parameter int RESERVED_IDX = 63,
  parameter int FIRST_IDX    = 0,
  parameter int CLK_MHZ      = 200,
  parameter int LOAD_NS      = 10000,
  localparam int WORD_BYTES  = 8,
  localparam int WORD_W      = WORD_BYTES * 8,
  localparam int ADDR_W      = IDX_W + $clog2(WORD_BYTES),
  localparam int LOAD_CYCLES = CLK_MHZ * LOAD_NS / 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data_valid,
  input  logic [7:0]        rd_data,
  input  logic              cond_met,
  input  logic [IDX_W-1:0]  next_idx,
  output logic [WORD_W-1:0] state_word,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              busy,
  output logic              idx_err
);
  logic              busy_q, kick_q, err_q;
  logic [IDX_W-1:0]  fetch_idx_q, cur_idx_q;
  logic [WORD_W-1:0] word_q, asm_word;
  logic              accept, reject, bytes_done, expired, commit;

  sll_index_guard #(.IDX_W(IDX_W), .RESERVED_IDX(RESERVED_IDX)) u_guard (
    .cond_met (cond_met),
    .idle     (!busy_q),
    .next_idx (next_idx),
    .accept   (accept),
    .reject   (reject)
  );

  sll_byte_fetch #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (kick_q),
    .slot      (fetch_idx_q),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .addr      (rd_addr),
    .rsp_valid (rd_data_valid),
    .rsp_data  (rd_data),
    .word_o    (asm_word),
    .done_o    (bytes_done)
  );

  sll_load_timer #(.CYCLES(LOAD_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (kick_q),
    .expired_o (expired)
  );

  assign commit = busy_q && !kick_q && bytes_done && expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b1;
      kick_q      <= 1'b1;
      err_q       <= 1'b0;
      fetch_idx_q <= IDX_W'(FIRST_IDX);
      cur_idx_q   <= IDX_W'(FIRST_IDX);
      word_q      <= '0;
    end else begin
      kick_q <= accept;
      err_q  <= reject;
      if (accept) begin
        busy_q      <= 1'b1;
        fetch_idx_q <= next_idx;
      end else if (commit) begin
        busy_q    <= 1'b0;
        word_q    <= asm_word;
        cur_idx_q <= fetch_idx_q;
      end
    end
  end

  assign state_word = word_q;
  assign cur_idx    = cur_idx_q;
  assign busy       = busy_q;
  assign idx_err    = err_q;
endmodule

// File: rtl/sll_checker.sv
module sll_checker #(
  parameter int IDX_W        = 6,
  parameter int RESERVED_IDX = 63,
  parameter int ADDR_W       = 9,
  parameter int WORD_W       = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_data_valid,
  input logic              cond_met,
  input logic [IDX_W-1:0]  next_idx,
  input logic [WORD_W-1:0] state_word,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              busy,
  input logic              idx_err
);
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> !rd_req_valid);

  a_r8_no_reserved_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_addr[ADDR_W-1 -: IDX_W] != IDX_W'(RESERVED_IDX)));

  a_r3_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy -> ($stable(state_word) && $stable(cur_idx))));

  a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cond_met && next_idx != IDX_W'(RESERVED_IDX)) |=> busy);

  a_r6_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cond_met && next_idx == IDX_W'(RESERVED_IDX))
      |=> (idx_err && !busy && $stable(state_word) && $stable(cur_idx)));

  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> !idx_err);
endmodule

bind seq_state_loader sll_checker #(
  .IDX_W(IDX_W), .RESERVED_IDX(RESERVED_IDX), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_sll_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_req_valid  (rd_req_valid),
  .rd_req_ready  (rd_req_ready),
  .rd_addr       (rd_addr),
  .rd_data_valid (rd_data_valid),
  .cond_met      (cond_met),
  .next_idx      (next_idx),
  .state_word    (state_word),
  .cur_idx       (cur_idx),
  .busy          (busy),
  .idx_err       (idx_err)
);

// File: tb/seq_state_loader_bench.sv
module seq_state_loader_bench;
  localparam int LC = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req_valid, rd_req_ready = 1'b1;
  logic [8:0]  rd_addr;
  logic        rd_data_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        cond_met = 1'b0;
  logic [5:0]  next_idx = '0;
  logic [63:0] state_word;
  logic [5:0]  cur_idx;
  logic        busy, idx_err;

  always #2.5 clk = ~clk;

  seq_state_loader #(.IDX_W(6), .RESERVED_IDX(63), .FIRST_IDX(0),
                     .CLK_MHZ(200), .LOAD_NS(10000)) u_seq_state_loader (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .cond_met(cond_met), .next_idx(next_idx),
    .state_word(state_word), .cur_idx(cur_idx), .busy(busy), .idx_err(idx_err)
  );

  logic [7:0] mem [512];
  int   total = 0, fails = 0;
  logic [1:0] mode = 2'd0;
  int   exp_slot = 0, seq_ptr = 0, addr_bad = 0, tick = 0;
  logic pending = 1'b0;
  logic [8:0] paddr = '0;

  // idx[7:2], storage mode[1:0]: 0 fast, 1 irregular grant, 2 very slow grant
  localparam logic [7:0] VECS [6] = '{
    {6'd5, 2'd0}, {6'd62, 2'd0}, {6'd1, 2'd1},
    {6'd0, 2'd0}, {6'd33, 2'd1}, {6'd17, 2'd2}
  };

  function automatic logic [63:0] exp_word(input int s);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = mem[s*8 + k];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // storage model, driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      tick++;
      rd_data_valid = pending;
      rd_data       = mem[paddr];
      pending       = 1'b0;
      case (mode)
        2'd0: rd_req_ready = 1'b1;
        2'd1: rd_req_ready = tick[0] ^ tick[2];
        default: rd_req_ready = (tick % 300 == 0);
      endcase
      if (rd_req_valid && rd_req_ready) begin
        pending = 1'b1;
        paddr   = rd_addr;
        if (rd_addr != 9'(exp_slot * 8 + seq_ptr)) addr_bad++;
        seq_ptr++;
      end
    end
  end

  task automatic step(input logic [5:0] idx, input logic [1:0] md);
    int n;
    logic [63:0] prev;
    prev = state_word;
    mode = md; exp_slot = idx; seq_ptr = 0; addr_bad = 0;
    cond_met = 1'b1; next_idx = idx;
    @(negedge clk);
    cond_met = 1'b0;
    chk(busy == 1'b1, "R4 busy rises", 64'(busy), 64'd1);
    chk(state_word == prev, "R3 word held", state_word, prev);
    n = 0;
    while (busy && n < 30000) begin n++; @(negedge clk); end
    chk(state_word == exp_word(idx), "R2 word", state_word, exp_word(idx));
    chk(cur_idx == idx, "R2 cur_idx", 64'(cur_idx), 64'(idx));
    chk(addr_bad == 0 && seq_ptr == 8, "R8 addresses", 64'(addr_bad), 64'd0);
    if (md == 2'd0) chk(n == LC + 1, "R4 busy length", 64'(n), 64'(LC + 1));
    if (md == 2'd2) chk(n > LC + 1, "R9 waits for bytes", 64'(n), 64'(LC + 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int a = 0; a < 512; a++) mem[a] = 8'(a * 29 + 7) ^ 8'(a >> 3);
    exp_slot = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b1, "R1 busy in reset", 64'(busy), 64'd1);
    chk(state_word == 64'd0, "R1 word in reset", state_word, 64'd0);
    chk(idx_err == 1'b0, "R1 err in reset", 64'(idx_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(state_word == exp_word(0), "R1 first load", state_word, exp_word(0));
    chk(cur_idx == 6'd0, "R1 first idx", 64'(cur_idx), 64'd0);

    for (int i = 0; i < 6; i++) step(VECS[i][7:2], VECS[i][1:0]);

    // R6 reserved slot
    begin
      logic [63:0] w;
      w = state_word;
      cond_met = 1'b1; next_idx = 6'd63;
      @(negedge clk);
      cond_met = 1'b0;
      chk(idx_err == 1'b1, "R6 err pulse", 64'(idx_err), 64'd1);
      chk(busy == 1'b0, "R6 no fetch", 64'(busy), 64'd0);
      @(negedge clk);
      chk(idx_err == 1'b0, "R6 err one cycle", 64'(idx_err), 64'd0);
      repeat (20) @(negedge clk);
      chk(state_word == w && cur_idx == 6'd17, "R6 state kept", state_word, w);
    end

    // R5 strobe during busy ignored
    mode = 2'd0; exp_slot = 10; seq_ptr = 0; addr_bad = 0;
    cond_met = 1'b1; next_idx = 6'd10;
    @(negedge clk);
    next_idx = 6'd20;
    repeat (50) @(negedge clk);
    cond_met = 1'b0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(cur_idx == 6'd10, "R5 idx kept", 64'(cur_idx), 64'd10);
    chk(state_word == exp_word(10), "R5 word kept", state_word, exp_word(10));
    chk(busy == 1'b0 && seq_ptr == 8, "R5 no extra fetch", 64'(seq_ptr), 64'd8);

    // R7 storage edit seen on next fetch
    mem[10*8 + 0] = 8'hA5;
    mem[10*8 + 7] = 8'h3C;
    chk(state_word[7:0] != 8'hA5, "R7 no early effect", 64'(state_word[7:0]), 64'd0);
    step(6'd10, 2'd0);
    chk(state_word[7:0] == 8'hA5 && state_word[63:56] == 8'h3C, "R7 edit loaded",
        state_word, exp_word(10));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule